// File: doc/BRIEF.md
# Burst Waveform RAM Loader

This block turns a stream of register writes into a burst of writes to one bank of a waveform sample memory. Software stores the first 64-bit data word, then issues a control write carrying a one-shot start command together with a burst length and a start address, and then writes the remaining words one after another. The loader commits the stored word to the start address when the start command is accepted. It places each later word at the next address and counts words against the burst length. When the count is reached it drops its busy flag.

Each 64-bit word carries four 16-bit lanes. Each lane holds one 14-bit sample in bits [14:1]. A data path that uses both banks places one instance per bank. The even bank takes samples n, n+2, n+4 and n+6 in lanes 0 to 3, and the odd bank takes n+1, n+3, n+5 and n+7. The two instances share no state. Words sent after the burst is complete are dropped. A burst that is left short never times out: it stays open until the missing words arrive or a software reset aborts it.

Top module: `burst_ram_loader`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` and `ram_we` are low.
- R2: A data write in the idle state does not write the RAM; it replaces the held word. A control write with `ctrl_start` set, a nonzero `burst_len` and the loader idle writes the held word (packed per R8) to `start_addr`, with `ram_we` high in the cycle after the strobe edge.
- R3: After an accepted start, each data write produces a RAM write one cycle later at the next address, modulo 2^ADDR_W. A burst holds exactly `burst_len` words, the first word included. `busy` is high from the start until the cycle in which the last word is written, and low from then on.
- R4: Data writes arriving after the burst count has been reached never raise `ram_we`.
- R5: If fewer words than `burst_len` arrive, `busy` stays high however long the input stays quiet, and the next data write continues the burst at the next address.
- R6: `sw_rst` aborts any burst. In the following cycle `busy` and `ram_we` are low, and later data writes do not reach the RAM until a new start.
- R7: A start with `burst_len` equal to zero is ignored: no RAM write, and `busy` stays low.
- R8: On `ram_wdata`, bits [14:1] of every 16-bit lane equal the same bits of the source word, and bits 0 and 15 of every lane are zero.
- R9: A start command or a new `burst_len`/`start_addr` presented while busy has no effect: no extra write, the burst length is unchanged, and the address sequence continues.
- R10: A data write in the same cycle as an accepted start is dropped. The start commits the word held before that cycle, and the next data write goes to `start_addr`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_rst | input | 1 | Synchronous software abort |
| data_wr | input | 1 | Strobe for a data-register write |
| data_in | input | 64 | Data-register write value |
| ctrl_wr | input | 1 | Strobe for a control-register write |
| ctrl_start | input | 1 | Start command bit of the control write; acts only in the cycle of the strobe |
| burst_len | input | LEN_W | Number of words in the burst, sampled at start |
| start_addr | input | ADDR_W | First RAM address of the burst, sampled at start |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 64 | Packed RAM write data |
| busy | output | 1 | Burst in progress |

## Verification
Every burst length from one to six is swept from several start addresses, one of them close enough to the top of a 16-entry space that the address must wrap. A loader that numbered words from zero, or that counted the first word twice, would write one word too many or too few, and the write sent after the burst tells these apart. A long idle gap inside a short burst catches a design that times out. A start sent while busy catches one that restarts the burst or takes the new length. A data write in the same cycle as the start catches a loader that holds or writes the wrong word. An all-ones word checks the lane padding, and a zero length checks that a start with no words is refused.

// File: rtl/blw_pkg.sv
package blw_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } blw_state_e;

endpackage

// File: rtl/blw_lane_packer.sv
module blw_lane_packer #(
  parameter int LANES      = 4,
  parameter int LANE_W     = 16,
  parameter int SAMPLE_W   = 14,
  parameter int SAMPLE_LSB = 1,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] packed_word
);

  localparam logic [LANE_W-1:0] LANE_KEEP =
    LANE_W'(((64'd1 << SAMPLE_W) - 64'd1) << SAMPLE_LSB);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign packed_word[g*LANE_W +: LANE_W] = raw[g*LANE_W +: LANE_W] & LANE_KEEP;
  end

endmodule

// File: rtl/blw_burst_counter.sv
module blw_burst_counter #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              start_ok,
  input  logic              word_ok,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  burst_len,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              last_word
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [LEN_W-1:0]  CNT_ONE  = LEN_W'(1);

  logic [ADDR_W-1:0] nxt_addr_q, nxt_addr_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              cnt_en;

  assign wr_addr   = start_ok ? start_addr : nxt_addr_q;
  assign last_word = (cnt_q + CNT_ONE) == len_q;
  assign cnt_en    = sw_rst | start_ok | word_ok;

  always_comb begin
    nxt_addr_d = nxt_addr_q;
    cnt_d      = cnt_q;
    len_d      = len_q;
    if (sw_rst) begin
      nxt_addr_d = start_addr;
      cnt_d      = '0;
    end else if (start_ok) begin
      nxt_addr_d = start_addr + ADDR_ONE;
      cnt_d      = CNT_ONE;
      len_d      = burst_len;
    end else if (word_ok) begin
      nxt_addr_d = nxt_addr_q + ADDR_ONE;
      cnt_d      = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_addr_q <= '0;
      cnt_q      <= '0;
      len_q      <= '0;
    end else if (cnt_en) begin
      nxt_addr_q <= nxt_addr_d;
      cnt_q      <= cnt_d;
      len_q      <= len_d;
    end
  end

  AST_CNT_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_q) else $error("word count passed burst length"); // R3

  AST_WORD_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && !start_ok && !sw_rst) |=> (nxt_addr_q == $past(nxt_addr_q) + ADDR_ONE))
    else $error("address did not advance"); // R3

endmodule

// File: rtl/blw_burst_fsm.sv
module blw_burst_fsm
  import blw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic data_wr,
  input  logic start_req,
  input  logic len_zero,
  input  logic len_one,
  input  logic last_word,
  output logic start_ok,
  output logic word_ok,
  output logic hold_en,
  output logic busy
);

  blw_state_e state_q, state_d;

  assign start_ok = (state_q == ST_IDLE) & start_req & ~len_zero & ~sw_rst;
  assign word_ok  = (state_q == ST_BURST) & data_wr & ~sw_rst;
  assign hold_en  = (state_q == ST_IDLE) & data_wr & ~start_req & ~sw_rst;
  assign busy     = (state_q == ST_BURST);

  always_comb begin
    state_d = state_q;
    if (sw_rst) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (start_ok && !len_one) state_d = ST_BURST;
        ST_BURST: if (word_ok && last_word) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ok) else $error("start accepted while busy"); // R9

  AST_SWRST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !busy) else $error("software reset left burst open"); // R6

endmodule

// File: rtl/burst_ram_loader.sv
module burst_ram_loader #(
  parameter int ADDR_W     = 10,
  parameter int LEN_W      = 10,
  parameter int LANES      = 4,
  parameter int LANE_W     = 16,
  parameter int SAMPLE_W   = 14,
  parameter int SAMPLE_LSB = 1,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ctrl_wr,
  input  logic              ctrl_start,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              busy
);

  localparam logic [LANE_W-1:0] LANE_PAD =
    ~LANE_W'(((64'd1 << SAMPLE_W) - 64'd1) << SAMPLE_LSB);
  localparam logic [DATA_W-1:0] PAD_MASK = {LANES{LANE_PAD}};

  logic              start_req, len_zero, len_one;
  logic              start_ok, word_ok, hold_en, last_word;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] src_word, packed_word;
  logic              we_d, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign start_req = ctrl_wr & ctrl_start;
  assign len_zero  = (burst_len == '0);
  assign len_one   = (burst_len == LEN_W'(1));

  blw_burst_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .data_wr   (data_wr),
    .start_req (start_req),
    .len_zero  (len_zero),
    .len_one   (len_one),
    .last_word (last_word),
    .start_ok  (start_ok),
    .word_ok   (word_ok),
    .hold_en   (hold_en),
    .busy      (busy)
  );

  blw_burst_counter #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .start_ok   (start_ok),
    .word_ok    (word_ok),
    .start_addr (start_addr),
    .burst_len  (burst_len),
    .wr_addr    (wr_addr),
    .last_word  (last_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= data_in;
  end

  assign src_word = start_ok ? hold_q : data_in;

  blw_lane_packer #(
    .LANES      (LANES),
    .LANE_W     (LANE_W),
    .SAMPLE_W   (SAMPLE_W),
    .SAMPLE_LSB (SAMPLE_LSB)
  ) u_pack (
    .raw         (src_word),
    .packed_word (packed_word)
  );

  assign we_d = start_ok | word_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (we_d) begin
      addr_q  <= wr_addr;
      wdata_q <= packed_word;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctrl_wr) |=> !ram_we) else $error("write while idle"); // R4

  AST_START_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl_wr && ctrl_start && !len_zero && !sw_rst)
      |=> (ram_we && ram_addr == $past(start_addr)))
    else $error("start did not commit at base"); // R2

  AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl_wr && len_zero) |=> (!ram_we && !busy))
    else $error("zero-length start acted"); // R7

  AST_BURST_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_wr && !sw_rst) |=> ram_we)
    else $error("burst word lost"); // R3

  AST_SWRST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !ram_we) else $error("write after abort"); // R6

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wdata & PAD_MASK) == '0) else $error("lane padding set"); // R8

endmodule

// File: tb/test_burst_ram_loader.sv
module test_burst_ram_loader;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int LW = 5;
  localparam logic [63:0] KEEP = 64'h7FFE_7FFE_7FFE_7FFE;

  logic          clk, rst_n, sw_rst;
  logic          data_wr, ctrl_wr, ctrl_start;
  logic [63:0]   data_in;
  logic [LW-1:0] burst_len;
  logic [AW-1:0] start_addr;
  logic          ram_we, busy;
  logic [AW-1:0] ram_addr;
  logic [63:0]   ram_wdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  burst_ram_loader #(.ADDR_W(AW), .LEN_W(LW)) i_burst_ram_loader (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .data_wr(data_wr), .data_in(data_in),
    .ctrl_wr(ctrl_wr), .ctrl_start(ctrl_start),
    .burst_len(burst_len), .start_addr(start_addr),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] mkw(int a, int b);
    logic [31:0] hi, lo;
    hi = 32'(a) * 32'h0001_9E37 + 32'(b) * 32'h0000_0101;
    lo = (32'(b) * 32'h7F4A_7C15) ^ (32'(a) << 7) ^ 32'hC3A5_5A3C;
    return {hi, lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_data(input logic [63:0] w);
    data_in = w; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic send_start(input int len, input int addr, input bit with_data, input logic [63:0] w);
    burst_len = LW'(len); start_addr = AW'(addr);
    ctrl_wr = 1'b1; ctrl_start = 1'b1;
    data_wr = with_data; data_in = w;
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_start = 1'b0; data_wr = 1'b0;
  endtask

  task automatic expect_write(input string tag, input int addr, input logic [63:0] w, input bit exp_busy);
    chk(ram_we === 1'b1, {tag, " we"}, 64'(ram_we), 64'd1);
    chk(ram_addr === AW'(addr), {tag, " addr"}, 64'(ram_addr), 64'(AW'(addr)));
    chk(ram_wdata === (w & KEEP), {tag, " data"}, ram_wdata, w & KEEP);
    chk(busy === exp_busy, {tag, " busy"}, 64'(busy), 64'(exp_busy));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_rst = 1'b0; data_wr = 1'b0; ctrl_wr = 1'b0; ctrl_start = 1'b0;
    data_in = '0; burst_len = '0; start_addr = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && ram_we === 1'b0, "R1 in reset", {busy, ram_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && ram_we === 1'b0, "R1 after reset", {busy, ram_we}, 0);

    // R2 R3 R4: sweep of lengths and bases, including wrap from 14
    for (int len = 1; len <= 6; len++) begin
      for (int si = 0; si < 3; si++) begin
        int base;
        base = (si == 0) ? 0 : (si == 1) ? 3 : 14;
        send_data(mkw(len, base));
        chk(ram_we === 1'b0, "R2 idle data no write", 64'(ram_we), 0);
        send_start(len, base, 1'b0, '0);
        expect_write("R2 first word", base, mkw(len, base), len > 1);
        for (int k = 1; k < len; k++) begin
          send_data(mkw(len * 16 + k, base));
          expect_write("R3 burst word", (base + k) % 16, mkw(len * 16 + k, base), k < len - 1);
        end
        send_data(mkw(99, len));
        chk(ram_we === 1'b0, "R4 extra word dropped", 64'(ram_we), 0);
        chk(busy === 1'b0, "R4 idle after extra", 64'(busy), 0);
      end
    end

    // R7: zero length
    send_data(mkw(7, 7));
    send_start(0, 5, 1'b0, '0);
    chk(ram_we === 1'b0 && busy === 1'b0, "R7 zero length ignored", {busy, ram_we}, 0);
    send_data(mkw(7, 8));
    chk(ram_we === 1'b0, "R7 no burst opened", 64'(ram_we), 0);

    // R5: short burst stays open
    send_data(mkw(5, 0));
    send_start(5, 9, 1'b0, '0);
    expect_write("R5 first", 9, mkw(5, 0), 1'b1);
    send_data(mkw(5, 1));
    expect_write("R5 second", 10, mkw(5, 1), 1'b1);
    repeat (40) @(negedge clk);
    chk(busy === 1'b1 && ram_we === 1'b0, "R5 still waiting", {busy, ram_we}, 2'b10);
    send_data(mkw(5, 2));
    expect_write("R5 resumed", 11, mkw(5, 2), 1'b1);

    // R6: software reset aborts
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    chk(busy === 1'b0 && ram_we === 1'b0, "R6 aborted", {busy, ram_we}, 0);
    send_data(mkw(6, 0));
    chk(ram_we === 1'b0 && busy === 1'b0, "R6 data after abort", {busy, ram_we}, 0);

    // R9: start while busy has no effect
    send_data(mkw(9, 0));
    send_start(4, 2, 1'b0, '0);
    expect_write("R9 first", 2, mkw(9, 0), 1'b1);
    send_start(1, 9, 1'b0, '0);
    chk(ram_we === 1'b0 && busy === 1'b1, "R9 restart ignored", {busy, ram_we}, 2'b10);
    for (int k = 1; k < 4; k++) begin
      send_data(mkw(9, k));
      expect_write("R9 continues", 2 + k, mkw(9, k), k < 3);
    end

    // R10: data in the start cycle is dropped
    send_data(mkw(10, 0));
    send_start(2, 5, 1'b1, mkw(10, 1));
    expect_write("R10 holds old word", 5, mkw(10, 0), 1'b1);
    send_data(mkw(10, 2));
    expect_write("R10 next address", 6, mkw(10, 2), 1'b0);

    // R8: padding on an all-ones word
    send_data('1);
    send_start(1, 0, 1'b0, '0);
    chk(ram_wdata === 64'h7FFE_7FFE_7FFE_7FFE, "R8 lane padding", ram_wdata, 64'h7FFE_7FFE_7FFE_7FFE);
    chk(busy === 1'b0, "R3 single word burst", 64'(busy), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule